// File: doc/BRIEF.md
# Serial Frame Transmitter with Line Control

This block turns bytes into asynchronous serial frames on a single output line. It draws bytes from a show-ahead FIFO into a one-byte holding stage. From there it moves them into a frame engine that drives the line. The line is paced by an external strobe that pulses once per sixteenth of a bit time. Baud generation and reception belong to other blocks.

An 8-bit line control register, written through a simple write strobe, sets the frame format. The format covers the data length from 5 to 8 bits, one or two stop bits, and whether a parity bit is present. The parity bit can be odd, even, or held at a fixed 1 or 0. A break bit pulls the line low at any time. Two status outputs tell the surrounding logic when the holding stage can take a byte and when the transmitter has nothing left to send.

Top module: `uart_tx_lc`

## Requirements
- R1: After reset `tx_o` is high, `thr_empty_o` is high and `idle_o` is high. The line stays high whenever no frame is in progress and break is clear.
- R2: A frame is one start bit (low), then the data bits least significant bit first, then the optional parity bit, then the stop bits (high). Each bit lasts exactly OVS (16) `tick_i` pulses, and `tx_o` changes only on the clock edge that samples a tick, or on a line control write.
- R3: Line control bits [1:0] give the data length: 0 sends 5 bits, 1 sends 6, 2 sends 7 and 3 sends 8. Unused upper bits of the byte are not sent.
- R4: Line control bit 2 gives one stop bit when 0 and two stop bits when 1.
- R5: Line control bit 3 inserts a parity bit. Bits [5:4] choose its value: 0 odd (an odd count of ones over data plus parity), 1 even, 2 a constant 1, 3 a constant 0. Parity covers only the data bits actually sent.
- R6: While line control bit 6 is set, `tx_o` is low. Frame timing runs on underneath, so clearing the bit returns the line to wherever the frame has reached.
- R7: The line control register resets to 8'h03, giving 8 data bits, no parity and one stop bit.
- R8: The format is captured when a frame starts. A line control write during a frame affects only later frames; only the break bit acts at once.
- R9: When the holding stage is full at the tick that ends the last stop bit, the next start bit begins on that same tick, with no idle bit time between frames.
- R10: `fifo_rd_o` pops one byte only when `fifo_empty_i` is low and the holding stage is empty or is handing its byte to the frame engine on that cycle. `thr_empty_o` is high exactly when the holding stage holds no byte.
- R11: `idle_o` is high exactly when no frame is in progress and the holding stage is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling strobe, OVS pulses per bit |
| lcr_we_i | input | 1 | Line control write strobe |
| lcr_wdata_i | input | 8 | Line control write value |
| fifo_empty_i | input | 1 | Transmit FIFO has no byte |
| fifo_data_i | input | 8 | Head byte of the transmit FIFO (show-ahead) |
| fifo_rd_o | output | 1 | Pop the head byte this cycle |
| tx_o | output | 1 | Serial line, idles high |
| thr_empty_o | output | 1 | Holding stage is empty |
| idle_o | output | 1 | No frame in progress and holding stage empty |

## Verification
The bench builds the block with its default OVS of 16 ticks per bit. It runs the tick strobe at three cadences: every clock, every second clock and every third clock. The every-clock cadence puts a tick on the cycles where a frame ends and a new byte is fetched, so the back-to-back handover and the same-cycle refill of the holding stage are exercised. The slower cadences show that the line holds its value between ticks. The parity cases use 7-bit data, so the masking of the unsent top bit is tested as well.

// File: rtl/uart_tx_lc_pkg.sv
package uart_tx_lc_pkg;

  localparam int unsigned DATA_MAX = 8;
  localparam logic [7:0]  LCR_RESET = 8'h03;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_st_e;

  typedef enum logic [1:0] {
    PM_ODD   = 2'd0,
    PM_EVEN  = 2'd1,
    PM_ONE   = 2'd2,
    PM_ZERO  = 2'd3
  } par_mode_e;

  typedef struct packed {
    logic      rsvd;
    logic      brk;
    par_mode_e pmode;
    logic      pen;
    logic      stop2;
    logic [1:0] wlen;
  } lcr_t;

  // data mask for the configured length (5..8 bits)
  function automatic logic [DATA_MAX-1:0] data_mask(logic [1:0] wlen);
    return {DATA_MAX{1'b1}} >> (2'd3 - wlen);
  endfunction

  function automatic logic par_bit(lcr_t c, logic [DATA_MAX-1:0] d);
    logic x;
    x = ^(d & data_mask(c.wlen));
    case (c.pmode)
      PM_ODD:  return ~x;
      PM_EVEN: return x;
      PM_ONE:  return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/uart_tx_lc_reg.sv
module uart_tx_lc_reg
  import uart_tx_lc_pkg::*;
#(
  parameter logic [7:0] RST_VAL = LCR_RESET
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output lcr_t       lcr_o
);

  lcr_t lcr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lcr_q <= lcr_t'(RST_VAL);
    else if (we_i) lcr_q <= lcr_t'(wdata_i);
  end

  assign lcr_o = lcr_q;

endmodule

// File: rtl/uart_tx_lc_hold.sv
module uart_tx_lc_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          fifo_empty_i,
  input  logic [DW-1:0] fifo_data_i,
  output logic          fifo_rd_o,
  output logic          full_o,
  output logic [DW-1:0] data_o
);

  logic          full_q;
  logic [DW-1:0] data_q;

  // refill in the same cycle the byte leaves
  assign fifo_rd_o = !fifo_empty_i && (!full_q || take_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (fifo_rd_o) begin
      full_q <= 1'b1;
      data_q <= fifo_data_i;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

endmodule

// File: rtl/uart_tx_lc_frame.sv
module uart_tx_lc_frame
  import uart_tx_lc_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  lcr_t                lcr_i,
  input  logic                hold_full_i,
  input  logic [DATA_MAX-1:0] hold_data_i,
  output logic                take_o,
  output logic                busy_o,
  output logic                line_o
);

  localparam int unsigned CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int unsigned IW = $clog2(DATA_MAX);
  localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);

  tx_st_e              st_q;
  logic [CW-1:0]       cnt_q;
  logic [IW-1:0]       bit_q;
  logic                stop_q;
  lcr_t                cfg_q;
  logic [DATA_MAX-1:0] sh_q;
  logic                par_q;

  logic bit_end, data_last, frame_last;

  assign bit_end    = (cnt_q == CNT_LAST);
  assign data_last  = (bit_q == IW'(3'd4 + {1'b0, cfg_q.wlen}));
  assign frame_last = (st_q == ST_STOP) && bit_end && (stop_q == cfg_q.stop2);
  assign take_o     = tick_i && hold_full_i && ((st_q == ST_IDLE) || frame_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      stop_q <= 1'b0;
      cfg_q  <= lcr_t'(LCR_RESET);
      sh_q   <= '0;
      par_q  <= 1'b0;
    end else if (tick_i) begin
      if (take_o) begin
        st_q  <= ST_START;
        cnt_q <= '0;
        bit_q <= '0;
        cfg_q <= lcr_i;
        sh_q  <= hold_data_i;
        par_q <= par_bit(lcr_i, hold_data_i);
      end else if (st_q != ST_IDLE) begin
        if (bit_end) begin
          cnt_q <= '0;
          case (st_q)
            ST_START: st_q <= ST_DATA;
            ST_DATA: begin
              if (data_last) begin
                st_q   <= cfg_q.pen ? ST_PAR : ST_STOP;
                stop_q <= 1'b0;
              end else begin
                bit_q <= bit_q + 1'b1;
                sh_q  <= sh_q >> 1;
              end
            end
            ST_PAR: begin
              st_q   <= ST_STOP;
              stop_q <= 1'b0;
            end
            ST_STOP: begin
              if (stop_q == cfg_q.stop2) st_q <= ST_IDLE;
              else                      stop_q <= 1'b1;
            end
            default: st_q <= ST_IDLE;
          endcase
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (st_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = sh_q[0];
      ST_PAR:   line_o = par_q;
      default:  line_o = 1'b1;
    endcase
  end

  assign busy_o = (st_q != ST_IDLE);

endmodule

// File: rtl/uart_tx_lc.sv
module uart_tx_lc
  import uart_tx_lc_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       lcr_we_i,
  input  logic [7:0] lcr_wdata_i,
  input  logic       fifo_empty_i,
  input  logic [7:0] fifo_data_i,
  output logic       fifo_rd_o,
  output logic       tx_o,
  output logic       thr_empty_o,
  output logic       idle_o
);

  lcr_t                lcr_q;
  logic                take, busy, line, hold_full;
  logic [DATA_MAX-1:0] hold_data;

  uart_tx_lc_reg #(.RST_VAL(LCR_RESET)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (lcr_we_i),
    .wdata_i (lcr_wdata_i),
    .lcr_o   (lcr_q)
  );

  uart_tx_lc_hold #(.DW(DATA_MAX)) u_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .take_i       (take),
    .fifo_empty_i (fifo_empty_i),
    .fifo_data_i  (fifo_data_i),
    .fifo_rd_o    (fifo_rd_o),
    .full_o       (hold_full),
    .data_o       (hold_data)
  );

  uart_tx_lc_frame #(.OVS(OVS)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .lcr_i       (lcr_q),
    .hold_full_i (hold_full),
    .hold_data_i (hold_data),
    .take_o      (take),
    .busy_o      (busy),
    .line_o      (line)
  );

  // break acts live, not at a frame boundary
  assign tx_o        = line & ~lcr_q.brk;
  assign thr_empty_o = ~hold_full;
  assign idle_o      = ~busy & ~hold_full;

endmodule

// File: rtl/uart_tx_lc_chk.sv
module uart_tx_lc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic lcr_we_i,
  input logic fifo_empty_i,
  input logic fifo_rd_o,
  input logic tx_o,
  input logic thr_empty_o,
  input logic idle_o,
  input logic brk_i
);

  // R2: the line only moves on a tick or a control write
  p_hold_between_ticks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !lcr_we_i) |=> $stable(tx_o));

  // R10: a pop always fills the holding stage
  p_pop_fills_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |=> !thr_empty_o);

  // R1: idle line is high unless break
  p_idle_line_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && !brk_i) |-> tx_o);

  // R11: nothing to send keeps the block idle
  p_stay_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && fifo_empty_i) |=> idle_o);

  // R6: break drives the line low
  p_break_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lcr_we_i) && brk_i) |-> !tx_o);

endmodule

bind uart_tx_lc uart_tx_lc_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .lcr_we_i     (lcr_we_i),
  .fifo_empty_i (fifo_empty_i),
  .fifo_rd_o    (fifo_rd_o),
  .tx_o         (tx_o),
  .thr_empty_o  (thr_empty_o),
  .idle_o       (idle_o),
  .brk_i        (lcr_q.brk)
);

// File: tb/uart_tx_lc_test.sv
`timescale 1ns/1ps
module uart_tx_lc_test;

  localparam int OVS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       lcr_we = 1'b0;
  logic [7:0] lcr_wdata = 8'h00;
  logic       fifo_empty = 1'b1;
  logic [7:0] fifo_data = 8'h00;
  logic       fifo_rd, tx, thr_empty, idle;

  uart_tx_lc #(.OVS(OVS)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .tick_i       (tick),
    .lcr_we_i     (lcr_we),
    .lcr_wdata_i  (lcr_wdata),
    .fifo_empty_i (fifo_empty),
    .fifo_data_i  (fifo_data),
    .fifo_rd_o    (fifo_rd),
    .tx_o         (tx),
    .thr_empty_o  (thr_empty),
    .idle_o       (idle)
  );

  always #4 clk = ~clk;

  int n_cmp = 0, n_fail = 0, cycles = 0, tdiv = 2, tcnt = 0;
  bit done = 0;
  string cur_req = "R1";

  bit [7:0] fq[$];
  bit       m_bits[$];
  bit       m_busy, m_hold, m_level, rd_dut, take, rd_m;
  bit [7:0] m_hold_data, m_lcr;
  int       m_left;

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic void refresh();
    fifo_empty = (fq.size() == 0);
    fifo_data  = (fq.size() == 0) ? 8'h00 : fq[0];
  endfunction

  // frame image from the requirements: data LSB first, parity, stops
  function automatic void build(bit [7:0] d, bit [7:0] l);
    int n, ones;
    n = 5 + int'(l[1:0]);
    ones = 0;
    m_bits.delete();
    for (int i = 0; i < n; i++) begin
      m_bits.push_back(d[i]);
      ones += d[i];
    end
    if (l[3]) begin
      case (l[5:4])
        2'd0: m_bits.push_back((ones % 2) == 0);
        2'd1: m_bits.push_back((ones % 2) == 1);
        2'd2: m_bits.push_back(1'b1);
        default: m_bits.push_back(1'b0);
      endcase
    end
    m_bits.push_back(1'b1);
    if (l[2]) m_bits.push_back(1'b1);
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_hold = 0; m_lcr = 8'h03; m_level = 1; m_left = 0;
      m_bits.delete();
    end else begin
      rd_dut = fifo_rd;
      if (tick && m_busy) begin
        m_left--;
        if (m_left == 0) begin
          if (m_bits.size() > 0) begin
            m_level = m_bits.pop_front();
            m_left  = OVS;
          end else m_busy = 0;
        end
      end
      take = tick && m_hold && !m_busy;
      rd_m = (fq.size() > 0) && (!m_hold || take);
      if (take) begin
        build(m_hold_data, m_lcr);
        m_busy = 1; m_level = 0; m_left = OVS; m_hold = 0;
      end
      chk("R10", "fifo_rd", rd_dut, rd_m);
      if (rd_m) begin
        m_hold = 1;
        m_hold_data = fq.pop_front();
      end
      if (lcr_we) m_lcr = lcr_wdata;
    end
  end

  // compare away from the edge, then drive the tick strobe
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(cur_req, "tx", tx, m_lcr[6] ? 0 : (m_busy ? m_level : 1));
      chk("R10", "thr_empty", thr_empty, !m_hold);
      chk("R11", "idle", idle, !m_busy && !m_hold);
    end
    tcnt = (tcnt + 1) % tdiv;
    tick = (tcnt == 0);
    refresh();
    if (cycles > 150000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

  task automatic push(bit [7:0] b);
    @(negedge clk);
    fq.push_back(b);
    refresh();
  endtask

  task automatic wr_lcr(bit [7:0] v);
    @(negedge clk);
    lcr_we = 1'b1; lcr_wdata = v;
    @(negedge clk);
    lcr_we = 1'b0;
  endtask

  task automatic wait_idle();
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!(idle && fq.size() == 0) && k < 20000);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "tx reset", tx, 1);
    chk("R1", "thr_empty reset", thr_empty, 1);
    chk("R1", "idle reset", idle, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    cur_req = "R7 R2";
    push(8'hA5); push(8'h3C);
    wait_idle();

    cur_req = "R3";
    for (int w = 0; w < 3; w++) begin
      wr_lcr(8'(w));
      push(8'hE3); push(8'h1F);
      wait_idle();
    end

    cur_req = "R4";
    wr_lcr(8'h07);
    push(8'h81);
    wait_idle();

    cur_req = "R5";
    for (int p = 0; p < 4; p++) begin
      wr_lcr(8'((p << 4) | 8'h0A));
      push(8'hD6); push(8'h80);
      wait_idle();
    end

    cur_req = "R9";
    tdiv = 1;
    wr_lcr(8'h03);
    push(8'h01); push(8'hFE); push(8'h55); push(8'hAA);
    wait_idle();

    cur_req = "R8";
    tdiv = 3;
    push(8'h96); push(8'h69);
    repeat (60) @(negedge clk);
    wr_lcr(8'h1C);
    wait_idle();

    cur_req = "R6";
    tdiv = 2;
    wr_lcr(8'h03);
    push(8'hC3);
    repeat (70) @(negedge clk);
    wr_lcr(8'h43);
    repeat (90) @(negedge clk);
    wr_lcr(8'h03);
    wait_idle();
    wr_lcr(8'h43);
    repeat (20) @(negedge clk);
    wr_lcr(8'h03);
    repeat (10) @(negedge clk);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

endmodule